// File: doc/BRIEF.md
# Timer Counter with Fast-Clear Flags

A 16-bit free-running counter clocked through a selectable prescaler, with a control register, one event flag per channel and an overflow flag, all reached through a simple byte-wide register bus. Each channel flag is set by a one-cycle event strobe from an external capture or compare datapath; the overflow flag sets when the counter wraps. Flags are normally cleared by writing a 1 to them. With the fast-clear mode bit set, the ordinary accesses software already makes clear them: any access to a channel's data register clears that channel's flag, and any access to either counter byte clears the overflow flag.

The timer can be switched off, stopped while the chip sits in low-power wait (which also stops a divide-by-64 tick exported to a pulse-accumulator neighbour), or stopped in debug freeze (which stops only the counter, leaving the tick running). A precision-mode bit, which accepts only the first control write after reset, chooses between a power-of-two divider select and a full 8-bit divide-by-N prescaler.

The register bus has no handshake: a read returns data combinationally in the cycle `bus_rd` is high, and a write or a read side effect takes effect at the next rising edge. Every access completes in one cycle, so there is no back-pressure.

Top module: `tmr_fastclr_timer`

## Requirements
- R1: After reset the control register (address 0x07) reads 0x00, both counter bytes (0x04 high, 0x05 low) read 0x00, and the channel flags (0x0E) and overflow flag (0x0F, bit 7) read 0.
- R2: With the enable bit (control bit 7) at 0 the counter holds its value and `div64_tick` stays low; with it at 1 `div64_tick` pulses once every 64 cycles.
- R3: In legacy mode (control bit 3 at 0) the counter advances once every 2^S cycles, S being bits 2:0 of the divider-select register at 0x08.
- R4: In precision mode (control bit 3 at 1) the counter advances once every P+1 cycles, P being the 8-bit prescaler register at 0x09.
- R5: Control bit 3 takes its value from the first write to the control register after reset; later writes leave it unchanged while the other control bits still update.
- R6: With stop-in-wait (control bit 6) at 1 and `lp_wait` high, the counter holds and `div64_tick` stays low.
- R7: With stop-in-freeze (control bit 5) at 1 and `dbg_freeze` high, the counter holds while `div64_tick` keeps pulsing every 64 cycles.
- R8: A pulse on `chan_evt[i]` sets bit i of 0x0E; writing 1 to that bit clears it, writing 0 leaves it; with fast-clear (control bit 4) at 0, accesses to channel data registers leave the flags unchanged.
- R9: With fast-clear at 1, a read or write of either byte of channel i's data register (addresses 0x10+2i and 0x11+2i, which read 0) clears flag i, and a read or write of either counter byte clears the overflow flag.
- R10: The overflow flag sets when the counter wraps from 0xFFFF to 0x0000, stays set through counter reads while fast-clear is 0, and clears on writing 1 to bit 7 of 0x0F.
- R11: When a flag's set event and a clear of that flag fall in the same cycle, the flag ends set.
- R12: Bits 2:0 of the control register read 0 whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| lp_wait | input | 1 | Chip is in low-power wait |
| dbg_freeze | input | 1 | Chip is in debug freeze |
| chan_evt | input | NCH | Per-channel event strobes |
| div64_tick | output | 1 | One-cycle pulse every 64 running cycles, for the pulse accumulator |

## Verification
The overflow flag is the hardest state to reach: only a full 65536-step wrap sets it, and no port loads the counter. The stimulus selects precision mode with a prescale of zero so the counter steps every cycle, reads both counter bytes to compute the exact distance to the wrap, and idles just past it; a second wrap repeats this with fast-clear enabled so that a counter write must clear the flag. Halt checks compare two counter reads a fixed cycle distance apart, a multiple of the divisor, so the prescaler phase does not matter.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int AW = 5;
  localparam int DW = 8;

  localparam logic [AW-1:0] A_CNT_HI = 5'h04;
  localparam logic [AW-1:0] A_CNT_LO = 5'h05;
  localparam logic [AW-1:0] A_CTRL   = 5'h07;
  localparam logic [AW-1:0] A_DIVSEL = 5'h08;
  localparam logic [AW-1:0] A_PSR    = 5'h09;
  localparam logic [AW-1:0] A_CFLG   = 5'h0E;
  localparam logic [AW-1:0] A_OFLG   = 5'h0F;
  localparam int            A_CHAN0  = 16;

  localparam int B_EN    = 7;
  localparam int B_SWAIT = 6;
  localparam int B_SFRZ  = 5;
  localparam int B_FAST  = 4;
  localparam int B_PREC  = 3;

  typedef struct packed {
    logic en;
    logic swait;
    logic sfrz;
    logic fast;
    logic prec;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PW = 8,
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          prec,
  input  logic [2:0]    divsel,
  input  logic [PW-1:0] psr,
  output logic          tick,
  output logic          div_tick
);
  logic [PW-1:0] pre_cnt;
  logic [PW:0]   leg_full;
  logic [PW-1:0] term;
  logic [TW-1:0] tap_cnt;

  assign leg_full = ({{PW{1'b0}}, 1'b1} << divsel) - {{PW{1'b0}}, 1'b1};
  assign term     = prec ? psr : leg_full[PW-1:0];
  assign tick     = run && (pre_cnt >= term);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      tap_cnt  <= '0;
      div_tick <= 1'b0;
    end else begin
      if (run) begin
        pre_cnt <= (pre_cnt >= term) ? '0 : pre_cnt + PW'(1);
        tap_cnt <= tap_cnt + TW'(1);
      end
      div_tick <= run && (&tap_cnt);
    end
  end

  AST_PRE_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pre_cnt)); // R2
  AST_TAP_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !div_tick); // R6
  AST_TAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> tap_cnt == $past(tap_cnt) + TW'(1)); // R7
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [CW-1:0] count,
  output logic          wrap
);
  assign wrap = inc && (&count);

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + CW'(1);
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> count == $past(count) + CW'(1)); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> count == '0); // R10
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_set,
  input  logic [NCH-1:0] chan_clr,
  input  logic           ovf_set,
  input  logic           ovf_clr,
  output logic [NCH-1:0] cflg,
  output logic           oflg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cflg <= '0;
      oflg <= 1'b0;
    end else begin
      cflg <= (cflg & ~chan_clr) | chan_set;
      oflg <= (oflg & ~ovf_clr) | ovf_set;
    end
  end

  AST_CH_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_set != '0) |=> ((cflg & $past(chan_set)) == $past(chan_set))); // R11
  AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> oflg); // R11
  AST_CH_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_clr != '0) && (chan_set == '0)) |=> ((cflg & $past(chan_clr)) == '0)); // R8
endmodule

// File: rtl/tmr_fastclr_timer.sv
module tmr_fastclr_timer
  import tmr_pkg::*;
#(
  parameter int NCH = 6,
  parameter int CW  = 16,
  parameter int PW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic           lp_wait,
  input  logic           dbg_freeze,
  input  logic [NCH-1:0] chan_evt,
  output logic           div64_tick
);
  ctrl_t         ctrl;
  logic          prec_lock;
  logic [2:0]    divsel;
  logic [PW-1:0] psr;
  logic          run, tick, inc, wrap;
  logic [CW-1:0] count;
  logic [NCH-1:0] cflg, chan_clr, fast_hit;
  logic          oflg, ovf_clr, acc;

  assign acc = bus_rd | bus_wr;

  // control, divider select and prescale registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      prec_lock <= 1'b0;
      divsel    <= '0;
      psr       <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL) begin
        ctrl.en    <= bus_wdata[B_EN];
        ctrl.swait <= bus_wdata[B_SWAIT];
        ctrl.sfrz  <= bus_wdata[B_SFRZ];
        ctrl.fast  <= bus_wdata[B_FAST];
        if (!prec_lock) begin
          ctrl.prec <= bus_wdata[B_PREC];
          prec_lock <= 1'b1;
        end
      end
      if (bus_addr == A_DIVSEL) divsel <= bus_wdata[2:0];
      if (bus_addr == A_PSR)    psr    <= bus_wdata[PW-1:0];
    end
  end

  assign run = ctrl.en && !(ctrl.swait && lp_wait);
  assign inc = tick && !(ctrl.sfrz && dbg_freeze);

  tmr_prescale #(.PW(PW), .TW(6)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .prec(ctrl.prec),
    .divsel(divsel), .psr(psr), .tick(tick), .div_tick(div64_tick)
  );

  tmr_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(inc), .count(count), .wrap(wrap)
  );

  // fast-clear decode, one pair of data-register addresses per channel
  for (genvar i = 0; i < NCH; i++) begin : g_chan
    localparam logic [AW-1:0] ADR_H = AW'(A_CHAN0 + 2 * i);
    localparam logic [AW-1:0] ADR_L = AW'(A_CHAN0 + 2 * i + 1);
    assign fast_hit[i] = ctrl.fast && acc &&
                         ((bus_addr == ADR_H) || (bus_addr == ADR_L));
  end

  assign chan_clr = fast_hit |
                    ((bus_wr && (bus_addr == A_CFLG)) ? bus_wdata[NCH-1:0] : '0);
  assign ovf_clr  = (bus_wr && (bus_addr == A_OFLG) && bus_wdata[7]) ||
                    (ctrl.fast && acc &&
                     ((bus_addr == A_CNT_HI) || (bus_addr == A_CNT_LO)));

  tmr_flags #(.NCH(NCH)) u_flg (
    .clk(clk), .rst_n(rst_n), .chan_set(chan_evt), .chan_clr(chan_clr),
    .ovf_set(wrap), .ovf_clr(ovf_clr), .cflg(cflg), .oflg(oflg)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT_HI: bus_rdata = count[CW-1 -: 8];
      A_CNT_LO: bus_rdata = count[7:0];
      A_CTRL:   bus_rdata = {ctrl.en, ctrl.swait, ctrl.sfrz, ctrl.fast, ctrl.prec, 3'b000};
      A_DIVSEL: bus_rdata = {5'b00000, divsel};
      A_PSR:    bus_rdata[PW-1:0] = psr;
      A_CFLG:   bus_rdata[NCH-1:0] = cflg;
      A_OFLG:   bus_rdata = {oflg, 7'b0000000};
      default:  bus_rdata = '0;
    endcase
  end

  AST_PREC_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    prec_lock |=> $stable(ctrl.prec)); // R5
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.sfrz && dbg_freeze) |=> $stable(count)); // R7
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.swait && lp_wait) |=> ($stable(count) && !div64_tick)); // R6
  AST_OVF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (oflg && !ctrl.fast && !(bus_wr && bus_addr == A_OFLG)) |=> oflg); // R10
  AST_CH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.fast && !(bus_wr && bus_addr == A_CFLG)) |=>
      ((cflg & $past(cflg)) == $past(cflg))); // R8
endmodule

// File: tb/test_tmr_fastclr_timer.sv
module test_tmr_fastclr_timer;
  localparam int NCH = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [4:0]     bus_addr = '0;
  logic           bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]     bus_wdata = '0;
  logic [7:0]     bus_rdata;
  logic           lp_wait = 1'b0, dbg_freeze = 1'b0;
  logic [NCH-1:0] chan_evt = '0;
  logic           div64_tick;

  int n_chk = 0, n_fail = 0, div_cnt = 0;
  logic [7:0] exp_q[$];
  string      req_q[$];
  logic       mon_rd = 1'b0;
  logic [7:0] a, b;

  always #4 clk = ~clk;

  tmr_fastclr_timer #(.NCH(NCH)) i_tmr_fastclr_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lp_wait(lp_wait), .dbg_freeze(dbg_freeze), .chan_evt(chan_evt),
    .div64_tick(div64_tick)
  );

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // monitor: pops the expected item for each checked read
  always @(negedge clk) begin
    #3;
    if (mon_rd) check(req_q.pop_front(), int'(bus_rdata), int'(exp_q.pop_front()));
  end

  always @(negedge clk) begin
    #1;
    if (div64_tick) div_cnt++;
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] ad, logic [7:0] d);
    bus_addr = ad; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(logic [4:0] ad, logic [7:0] e, string req);
    exp_q.push_back(e); req_q.push_back(req);
    bus_addr = ad; bus_rd = 1'b1; mon_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; mon_rd = 1'b0;
  endtask

  task automatic rd_val(logic [4:0] ad, output logic [7:0] v);
    bus_addr = ad; bus_rd = 1'b1;
    #3 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    rd_chk(5'h07, 8'h00, "R1 ctrl");
    rd_chk(5'h04, 8'h00, "R1 cnt hi");
    rd_chk(5'h05, 8'h00, "R1 cnt lo");
    rd_chk(5'h0E, 8'h00, "R1 cflg");
    rd_chk(5'h0F, 8'h00, "R1 oflg");
    // R2 disabled: counter and tick halted
    div_cnt = 0; idle(128);
    check("R2 tick off", div_cnt, 0);
    rd_chk(5'h05, 8'h00, "R2 cnt held");

    // legacy mode, divide by 8
    wr(5'h08, 8'h03);
    wr(5'h07, 8'h80);
    rd_chk(5'h07, 8'h80, "R5 first write");
    wr(5'h07, 8'h8F);
    rd_chk(5'h07, 8'h80, "R5 R12 later write");
    rd_val(5'h05, a); idle(63);
    rd_chk(5'h05, a + 8'd8, "R3 div8");
    div_cnt = 0; idle(640);
    check("R2 tick on", div_cnt, 10);

    // R6 wait stop
    wr(5'h07, 8'hC0); lp_wait = 1'b1;
    rd_val(5'h05, a); idle(99);
    rd_chk(5'h05, a, "R6 cnt held");
    div_cnt = 0; idle(256);
    check("R6 tick off", div_cnt, 0);
    lp_wait = 1'b0;

    // R7 freeze stop
    wr(5'h07, 8'hA0); dbg_freeze = 1'b1;
    rd_val(5'h05, a); idle(63);
    rd_chk(5'h05, a, "R7 cnt held");
    div_cnt = 0; idle(640);
    check("R7 tick runs", div_cnt, 10);
    dbg_freeze = 1'b0;
    rd_val(5'h05, a); idle(63);
    rd_chk(5'h05, a + 8'd8, "R3 resume");

    // R8 channel flags, fast clear off
    wr(5'h07, 8'h80);
    chan_evt = 6'b000101; @(negedge clk); chan_evt = '0;
    rd_chk(5'h0E, 8'h05, "R8 set");
    wr(5'h0E, 8'h00);
    rd_chk(5'h0E, 8'h05, "R8 write0");
    rd_val(5'h10, b);
    check("R9 chan reg reads 0", b, 0);
    wr(5'h11, 8'hAA);
    rd_chk(5'h0E, 8'h05, "R8 no fast");
    wr(5'h0E, 8'h01);
    rd_chk(5'h0E, 8'h04, "R8 w1c");
    chan_evt = 6'b000010; wr(5'h0E, 8'h02); chan_evt = '0;
    rd_chk(5'h0E, 8'h06, "R11 set wins");
    // R9 fast clear on channels
    wr(5'h07, 8'h90);
    rd_val(5'h14, b);
    rd_chk(5'h0E, 8'h02, "R9 read clr");
    wr(5'h13, 8'h12);
    rd_chk(5'h0E, 8'h00, "R9 write clr");

    // precision mode
    do_reset();
    wr(5'h09, 8'h04);
    wr(5'h07, 8'h88);
    rd_chk(5'h07, 8'h88, "R5 prec set");
    wr(5'h07, 8'h80);
    rd_chk(5'h07, 8'h88, "R5 prec kept");
    rd_val(5'h05, a); idle(49);
    rd_chk(5'h05, a + 8'd10, "R4 div5");

    // R10 overflow with divide by 1
    wr(5'h09, 8'h00);
    rd_val(5'h04, a); rd_val(5'h05, b);
    idle(65536 - int'({a, b}) + 8);
    rd_chk(5'h0F, 8'h80, "R10 set");
    rd_val(5'h05, b);
    rd_chk(5'h0F, 8'h80, "R10 read keeps");
    wr(5'h0F, 8'h00);
    rd_chk(5'h0F, 8'h80, "R10 write0");
    wr(5'h0F, 8'h80);
    rd_chk(5'h0F, 8'h00, "R10 w1c");
    wr(5'h07, 8'h98);
    idle(65536);
    rd_chk(5'h0F, 8'h80, "R10 set again");
    wr(5'h04, 8'h55);
    rd_chk(5'h0F, 8'h00, "R9 cnt access clr");

    finish_run();
  end
endmodule